// File: doc/BRIEF.md
# Dual-Bank Endpoint Handshake Controller

This block holds the control and status word of a single USB device endpoint. A transaction engine reports five kinds of event to it: a setup packet arrived, an OUT data packet arrived with its byte count, an IN packet was acknowledged by the host, a STALL handshake reached the host, and an isochronous packet was corrupted. The block answers with the handshake the engine must give to the next OUT or IN token: no reply, ACK, NAK or STALL. It also tells the engine which receive bank an OUT packet goes into and which data toggle is expected.

The processor reads the status word and writes it back. The handshake flags are write-zero-to-clear, so writing 1 to them is harmless. The processor arms a transmission by writing 1 to the packet-ready bit, and the hardware retires that bit. Received OUT packets alternate between two buffer banks, so the processor can empty one bank while the host fills the other. With the `PING_PONG` parameter cleared, only bank 0 is used. The FIFO storage and the packet serialiser sit outside this block.

Top module: `usb_ep_ctrl`

## Requirements
- R1: After reset the status word reads 0, `irq_o` is 0, and both handshake outputs read 0 (no reply).
- R2: The flags at word bits 0 (IN done), 1 (bank 0 full), 2 (setup pending), 3 (error/stall sent) and 6 (bank 1 full) clear when the processor writes 0 to them. Writing 1 to them has no effect. A hardware set in the same cycle wins over the clear.
- R3: Writing 1 to bit 4 (packet ready) sets it, and writing 0 has no effect. An accepted IN acknowledge clears bit 4 and sets bit 0. The clear wins over a processor set in the same cycle.
- R4: `in_rsp_o` is 0 when bit 15 (enable) is clear, otherwise 3 (STALL) when bit 5 (force stall) is set, otherwise 1 (ACK) when bit 4 is set, and otherwise 2 (NAK).
- R5: `out_rsp_o` is 0 when disabled, otherwise 3 under force stall, otherwise 2 while setup is pending or the target bank's full flag is set, and otherwise 1.
- R6: `rx_bank_o` names the target bank for the next OUT packet. Each accepted OUT packet sets that bank's full flag, and the target then moves to the other bank, starting from bank 0.
- R7: Bits 26:16 show the byte count of the oldest unread bank. When both banks are full, that is the current target bank. Otherwise it is bank 1 if only bank 1 is full, and bank 0 in every other case. A setup packet's count goes to bank 0.
- R8: Bit 11 and `tgl_o` give the data toggle. It inverts after each accepted OUT or IN transaction and is forced to 1 by a setup packet. The processor cannot write it.
- R9: A stall acknowledge sets bit 3 only when the endpoint is enabled, force stall is set and the type is not isochronous. An isochronous error sets bit 3 only on an enabled isochronous endpoint (type 1 or 5).
- R10: `irq_o` is high exactly while any of bits 0, 1, 2, 3 or 6 is set.
- R11: `ep_rst_i` clears bits 0 to 4 and 6, the toggle, both byte counts and the bank pointer. Bits 5, 7, 10:8 and 15 are kept.
- R12: Events are ignored when they are not accepted. An OUT event while the OUT reply is not ACK, or a setup event while the endpoint is disabled, leaves the word unchanged.
- R13: A processor write loads bit 5, bit 7, bits 10:8 (type: 0 control, 1/2/3 iso/bulk/interrupt OUT, 5/6/7 the IN equivalents) and bit 15. Bits 12 to 14 and 27 to 31 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_wr_i | input | 1 | Processor write strobe for the status word |
| cpu_wdata_i | input | 32 | Processor write data |
| ep_rst_i | input | 1 | Endpoint reset request |
| setup_i | input | 1 | Setup packet received |
| out_i | input | 1 | OUT data packet received |
| out_cnt_i | input | CNT_W | Byte count of the received packet |
| in_ack_i | input | 1 | Host acknowledged the IN packet |
| stall_ack_i | input | 1 | STALL handshake sent to the host |
| iso_err_i | input | 1 | Corrupted isochronous packet |
| out_rsp_o | output | 2 | Reply to the next OUT token (0 none, 1 ACK, 2 NAK, 3 STALL) |
| in_rsp_o | output | 2 | Reply to the next IN token (same encoding) |
| rx_bank_o | output | 1 | Bank the next OUT packet goes into |
| tgl_o | output | 1 | Expected data toggle |
| csr_o | output | 32 | Status word |
| irq_o | output | 1 | Endpoint interrupt |

## Verification
A directed sequence fills both banks in turn and then offers a third packet. This separates correct alternation and oldest-first byte-count display from a single-bank or newest-first design. Setup arrival, stall, endpoint reset, the isochronous type and the disabled state are each applied on purpose, so the NAK, STALL and no-reply answers are each seen. A long stream of random events and writes follows. The writes carry mostly-1 flag bits with occasional zeros, and events often arrive while they are not acceptable. A model compares every cycle, which exposes wrong set/clear priority and events that should have been ignored.

// File: rtl/ep_ctrl_pkg.sv
package ep_ctrl_pkg;
  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_ACK   = 2'd1,
    RSP_NAK   = 2'd2,
    RSP_STALL = 2'd3
  } ep_rsp_e;

  localparam int B_TXDONE = 0;
  localparam int B_RX0    = 1;
  localparam int B_SETUP  = 2;
  localparam int B_ERR    = 3;
  localparam int B_TXRDY  = 4;
  localparam int B_FSTALL = 5;
  localparam int B_RX1    = 6;
  localparam int B_DIR    = 7;
  localparam int B_TYPE   = 8;
  localparam int B_TGL    = 11;
  localparam int B_EN     = 15;
  localparam int B_CNT    = 16;
  localparam int CNT_MAX  = 11;

  typedef struct packed {
    logic txdone;
    logic rx0;
    logic setup;
    logic err;
    logic txrdy;
    logic rx1;
  } ep_flags_t;

  function automatic logic is_iso(input logic [2:0] typ);
    return typ[1:0] == 2'b01;
  endfunction
endpackage

// File: rtl/ep_flag_regs.sv
module ep_flag_regs
  import ep_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ep_rst_i,
  input  logic       cpu_wr_i,
  input  logic [7:0] wd_i,
  input  logic       set_txdone_i,
  input  logic [1:0] set_rx_i,
  input  logic       set_setup_i,
  input  logic       set_err_i,
  input  logic       clr_txrdy_i,
  output ep_flags_t  flags_o
);
  ep_flags_t q, nxt;
  logic unused_bits;
  assign unused_bits = ^{wd_i[7], wd_i[5]};

  always_comb begin
    nxt = q;
    if (cpu_wr_i) begin
      nxt.txdone = q.txdone & wd_i[B_TXDONE];
      nxt.rx0    = q.rx0    & wd_i[B_RX0];
      nxt.setup  = q.setup  & wd_i[B_SETUP];
      nxt.err    = q.err    & wd_i[B_ERR];
      nxt.rx1    = q.rx1    & wd_i[B_RX1];
      nxt.txrdy  = q.txrdy  | wd_i[B_TXRDY];
    end
    nxt.txdone = nxt.txdone | set_txdone_i;
    nxt.rx0    = nxt.rx0    | set_rx_i[0];
    nxt.rx1    = nxt.rx1    | set_rx_i[1];
    nxt.setup  = nxt.setup  | set_setup_i;
    nxt.err    = nxt.err    | set_err_i;
    nxt.txrdy  = nxt.txrdy  & ~clr_txrdy_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= '0;
    else if (ep_rst_i) q <= '0;
    else               q <= nxt;
  end

  assign flags_o = q;

  a_r2_write0_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_wr_i && !wd_i[B_RX0] && !set_rx_i[0] |=> !flags_o.rx0);
  a_r2_hw_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_setup_i && !ep_rst_i |=> flags_o.setup);
endmodule

// File: rtl/ep_rx_banks.sv
module ep_rx_banks
  import ep_ctrl_pkg::*;
#(
  parameter bit          PING_PONG = 1'b1,
  parameter int unsigned CNT_W     = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ep_rst_i,
  input  logic             setup_ok_i,
  input  logic             out_ok_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [1:0]       full_i,
  output logic             tgt_bank_o,
  output logic [CNT_W-1:0] cnt_o
);
  generate
    if (PING_PONG) begin : g_pp
      logic             cur_q;
      logic [CNT_W-1:0] cnt_q [2];
      logic             rd;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cur_q <= 1'b0; cnt_q[0] <= '0; cnt_q[1] <= '0;
        end else if (ep_rst_i) begin
          cur_q <= 1'b0; cnt_q[0] <= '0; cnt_q[1] <= '0;
        end else begin
          if (out_ok_i) cur_q <= ~cur_q;
          if (setup_ok_i)    cnt_q[0]     <= cnt_i;
          else if (out_ok_i) cnt_q[cur_q] <= cnt_i;
        end
      end

      // with both banks full the next target is also the oldest
      assign rd         = (&full_i) ? cur_q : full_i[1];
      assign tgt_bank_o = cur_q;
      assign cnt_o      = cnt_q[rd];

      a_r6_alternate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_ok_i && !ep_rst_i |=> tgt_bank_o != $past(tgt_bank_o));
    end else begin : g_single
      logic [CNT_W-1:0] cnt_q;
      logic             unused_full;
      assign unused_full = ^full_i;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     cnt_q <= '0;
        else if (ep_rst_i)               cnt_q <= '0;
        else if (setup_ok_i || out_ok_i) cnt_q <= cnt_i;
      end

      assign tgt_bank_o = 1'b0;
      assign cnt_o      = cnt_q;
    end
  endgenerate
endmodule

// File: rtl/ep_handshake.sv
module ep_handshake
  import ep_ctrl_pkg::*;
(
  input  logic    en_i,
  input  logic    fstall_i,
  input  logic    setup_pend_i,
  input  logic    tgt_full_i,
  input  logic    txrdy_i,
  output ep_rsp_e out_rsp_o,
  output ep_rsp_e in_rsp_o
);
  always_comb begin
    if (!en_i)                           out_rsp_o = RSP_NONE;
    else if (fstall_i)                   out_rsp_o = RSP_STALL;
    else if (setup_pend_i || tgt_full_i) out_rsp_o = RSP_NAK;
    else                                 out_rsp_o = RSP_ACK;

    if (!en_i)         in_rsp_o = RSP_NONE;
    else if (fstall_i) in_rsp_o = RSP_STALL;
    else if (txrdy_i)  in_rsp_o = RSP_ACK;
    else               in_rsp_o = RSP_NAK;
  end
endmodule

// File: rtl/usb_ep_ctrl.sv
module usb_ep_ctrl
  import ep_ctrl_pkg::*;
#(
  parameter bit          PING_PONG = 1'b1,
  parameter int unsigned CNT_W     = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_wr_i,
  input  logic [31:0]      cpu_wdata_i,
  input  logic             ep_rst_i,
  input  logic             setup_i,
  input  logic             out_i,
  input  logic [CNT_W-1:0] out_cnt_i,
  input  logic             in_ack_i,
  input  logic             stall_ack_i,
  input  logic             iso_err_i,
  output logic [1:0]       out_rsp_o,
  output logic [1:0]       in_rsp_o,
  output logic             rx_bank_o,
  output logic             tgl_o,
  output logic [31:0]      csr_o,
  output logic             irq_o
);
  localparam int unsigned CW = (CNT_W > CNT_MAX) ? CNT_MAX : CNT_W;

  logic       fstall_q, dir_q, en_q, tgl_q;
  logic [2:0] type_q;
  ep_flags_t  flags;
  ep_rsp_e    out_rsp, in_rsp;
  logic       tgt_bank, tgt_full, iso;
  logic       out_ok, in_ok, setup_ok, stall_ok, isoerr_ok;
  logic [1:0] set_rx;
  logic [CNT_W-1:0] cnt_show;
  logic       unused_wd;
  assign unused_wd = ^{cpu_wdata_i[31:16], cpu_wdata_i[14:11]};

  assign iso       = is_iso(type_q);
  assign tgt_full  = tgt_bank ? flags.rx1 : flags.rx0;
  assign out_ok    = out_i && (out_rsp == RSP_ACK);
  assign in_ok     = in_ack_i && (in_rsp == RSP_ACK);
  assign setup_ok  = setup_i && en_q;
  assign stall_ok  = stall_ack_i && en_q && fstall_q && !iso;
  assign isoerr_ok = iso_err_i && en_q && iso;
  assign set_rx    = out_ok ? (tgt_bank ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fstall_q <= 1'b0; dir_q <= 1'b0; type_q <= '0; en_q <= 1'b0;
    end else if (cpu_wr_i) begin
      fstall_q <= cpu_wdata_i[B_FSTALL];
      dir_q    <= cpu_wdata_i[B_DIR];
      type_q   <= cpu_wdata_i[B_TYPE +: 3];
      en_q     <= cpu_wdata_i[B_EN];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tgl_q <= 1'b0;
    else if (ep_rst_i)          tgl_q <= 1'b0;
    else if (setup_ok)          tgl_q <= 1'b1;
    else if (out_ok || in_ok)   tgl_q <= ~tgl_q;
  end

  ep_flag_regs u_flags (
    .clk_i, .rst_ni, .ep_rst_i, .cpu_wr_i,
    .wd_i         (cpu_wdata_i[7:0]),
    .set_txdone_i (in_ok),
    .set_rx_i     (set_rx),
    .set_setup_i  (setup_ok),
    .set_err_i    (stall_ok || isoerr_ok),
    .clr_txrdy_i  (in_ok),
    .flags_o      (flags)
  );

  ep_rx_banks #(.PING_PONG(PING_PONG), .CNT_W(CNT_W)) u_banks (
    .clk_i, .rst_ni, .ep_rst_i,
    .setup_ok_i (setup_ok),
    .out_ok_i   (out_ok),
    .cnt_i      (out_cnt_i),
    .full_i     ({flags.rx1, flags.rx0}),
    .tgt_bank_o (tgt_bank),
    .cnt_o      (cnt_show)
  );

  ep_handshake u_hs (
    .en_i         (en_q),
    .fstall_i     (fstall_q),
    .setup_pend_i (flags.setup),
    .tgt_full_i   (tgt_full),
    .txrdy_i      (flags.txrdy),
    .out_rsp_o    (out_rsp),
    .in_rsp_o     (in_rsp)
  );

  always_comb begin
    csr_o              = '0;
    csr_o[B_TXDONE]    = flags.txdone;
    csr_o[B_RX0]       = flags.rx0;
    csr_o[B_SETUP]     = flags.setup;
    csr_o[B_ERR]       = flags.err;
    csr_o[B_TXRDY]     = flags.txrdy;
    csr_o[B_FSTALL]    = fstall_q;
    csr_o[B_RX1]       = flags.rx1;
    csr_o[B_DIR]       = dir_q;
    csr_o[B_TYPE +: 3] = type_q;
    csr_o[B_TGL]       = tgl_q;
    csr_o[B_EN]        = en_q;
    csr_o[B_CNT +: CW] = cnt_show[CW-1:0];
  end

  assign irq_o     = flags.txdone | flags.rx0 | flags.rx1 | flags.setup | flags.err;
  assign out_rsp_o = out_rsp;
  assign in_rsp_o  = in_rsp;
  assign rx_bank_o = tgt_bank;
  assign tgl_o     = tgl_q;

  a_r3_in_ack_retires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ok && !ep_rst_i |=> !flags.txrdy && flags.txdone);
  a_r5_setup_blocks_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags.setup && !cpu_wr_i && !ep_rst_i |=> $stable(flags.rx0) && $stable(flags.rx1));
  a_r8_setup_data1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_ok && !ep_rst_i |=> tgl_o);
  a_r11_ep_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ep_rst_i |=> !irq_o && !tgl_o && !csr_o[B_TXRDY] && !rx_bank_o);
endmodule

// File: tb/usb_ep_ctrl_test.sv
module usb_ep_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0, ep_rst = 1'b0, su = 1'b0, o = 1'b0;
  logic        ia = 1'b0, sa = 1'b0, ie = 1'b0;
  logic [31:0] wd = '0;
  logic [10:0] cnt = '0;
  logic [1:0]  out_rsp, in_rsp;
  logic        rx_bank, tgl, irq;
  logic [31:0] csr;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  usb_ep_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_wr_i(cpu_wr), .cpu_wdata_i(wd),
    .ep_rst_i(ep_rst), .setup_i(su), .out_i(o), .out_cnt_i(cnt),
    .in_ack_i(ia), .stall_ack_i(sa), .iso_err_i(ie),
    .out_rsp_o(out_rsp), .in_rsp_o(in_rsp), .rx_bank_o(rx_bank),
    .tgl_o(tgl), .csr_o(csr), .irq_o(irq)
  );

  // reference model state
  logic m_txd, m_rx0, m_su, m_err, m_rdy, m_rx1, m_fst, m_dir, m_en, m_tgl, m_cur;
  logic [2:0]  m_typ;
  logic [10:0] m_c0, m_c1;

  function automatic logic [1:0] exp_out();
    if (!m_en) return 2'd0;
    if (m_fst) return 2'd3;
    if (m_su || (m_cur ? m_rx1 : m_rx0)) return 2'd2;
    return 2'd1;
  endfunction

  function automatic logic [1:0] exp_in();
    if (!m_en) return 2'd0;
    if (m_fst) return 2'd3;
    return m_rdy ? 2'd1 : 2'd2;
  endfunction

  function automatic logic [10:0] exp_cnt();
    if (m_rx0 && m_rx1) return m_cur ? m_c1 : m_c0;
    return m_rx1 ? m_c1 : m_c0;
  endfunction

  function automatic logic [31:0] exp_csr();
    logic [31:0] v = '0;
    v[0] = m_txd; v[1] = m_rx0; v[2] = m_su; v[3] = m_err; v[4] = m_rdy;
    v[5] = m_fst; v[6] = m_rx1; v[7] = m_dir; v[10:8] = m_typ; v[11] = m_tgl;
    v[15] = m_en; v[26:16] = exp_cnt();
    return v;
  endfunction

  task automatic model_reset();
    {m_txd, m_rx0, m_su, m_err, m_rdy, m_rx1, m_fst, m_dir, m_en, m_tgl, m_cur} = '0;
    m_typ = '0; m_c0 = '0; m_c1 = '0;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp();
    logic [31:0] e = exp_csr();
    check("R2 flags", {25'd0, csr[6:0] & 7'h5F}, {25'd0, e[6:0] & 7'h5F});
    check("R3 ready", {31'd0, csr[4]}, {31'd0, e[4]});
    check("R13 cfg", csr & 32'hF800_87A0, e & 32'hF800_87A0);
    check("R7 count", {21'd0, csr[26:16]}, {21'd0, e[26:16]});
    check("R8 toggle", {30'd0, csr[11], tgl}, {30'd0, m_tgl, m_tgl});
    check("R10 irq", {31'd0, irq}, {31'd0, m_txd | m_rx0 | m_rx1 | m_su | m_err});
    check("R5 out rsp", {30'd0, out_rsp}, {30'd0, exp_out()});
    check("R4 in rsp", {30'd0, in_rsp}, {30'd0, exp_in()});
    check("R6 bank", {31'd0, rx_bank}, {31'd0, m_cur});
  endtask

  task automatic model_step();
    logic iso, ook, iok, sok, stok, ieok;
    iso  = (m_typ[1:0] == 2'b01);
    ook  = o && exp_out() == 2'd1;
    iok  = ia && exp_in() == 2'd1;
    sok  = su && m_en;
    stok = sa && m_en && m_fst && !iso;
    ieok = ie && m_en && iso;
    if (cpu_wr) begin
      m_txd &= wd[0]; m_rx0 &= wd[1]; m_su &= wd[2]; m_err &= wd[3];
      m_rx1 &= wd[6]; m_rdy |= wd[4];
    end
    m_txd |= iok; m_su |= sok; m_err |= stok | ieok; m_rdy &= ~iok;
    if (ook) begin
      if (m_cur) m_rx1 = 1'b1; else m_rx0 = 1'b1;
    end
    if (sok) m_c0 = cnt;
    else if (ook) begin
      if (m_cur) m_c1 = cnt; else m_c0 = cnt;
    end
    if (ook) m_cur = ~m_cur;
    if (sok) m_tgl = 1'b1;
    else if (ook || iok) m_tgl = ~m_tgl;
    if (ep_rst) begin
      {m_txd, m_rx0, m_su, m_err, m_rdy, m_rx1, m_tgl, m_cur} = '0;
      m_c0 = '0; m_c1 = '0;
    end
    if (cpu_wr) begin
      m_fst = wd[5]; m_dir = wd[7]; m_typ = wd[10:8]; m_en = wd[15];
    end
  endtask

  // compare at the falling edge, then drive one cycle of stimulus
  task automatic drive(input logic w, input logic [31:0] d, input logic er,
                       input logic s, input logic op, input logic [10:0] c,
                       input logic a, input logic st, input logic e);
    @(negedge clk);
    cmp();
    cpu_wr = w; wd = d; ep_rst = er; su = s; o = op; cnt = c; ia = a; sa = st; ie = e;
    model_step();
  endtask

  task automatic idle();
    drive(0, 32'h0, 0, 0, 0, 11'd0, 0, 0, 0);
  endtask

  task automatic wr(input logic [31:0] d);
    drive(1, d, 0, 0, 0, 11'd0, 0, 0, 0);
    idle();
  endtask

  task automatic ev_out(input logic [10:0] c);
    drive(0, 32'h0, 0, 0, 1, c, 0, 0, 0);
    idle();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 csr", csr, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);
    check("R1 rsp", {28'd0, out_rsp, in_rsp}, 32'h0);

    wr(32'h0000_824F);                        // bulk OUT, enable, flag bits written 1
    check("R13 cfg load", csr, 32'h0000_8200);
    check("R4 in nak", {30'd0, in_rsp}, 32'd2);
    check("R5 out ack", {30'd0, out_rsp}, 32'd1);

    ev_out(11'd5);
    check("R6 bank0 filled", csr, 32'h0005_8A02);
    check("R6 target bank1", {31'd0, rx_bank}, 32'd1);
    check("R10 irq set", {31'd0, irq}, 32'd1);

    ev_out(11'd9);
    check("R7 oldest count", csr, 32'h0005_8242);
    check("R5 both full nak", {30'd0, out_rsp}, 32'd2);

    ev_out(11'd3);
    check("R12 nak out ignored", csr, 32'h0005_8242);

    wr(32'h0000_824D);                        // release bank 0
    check("R2 clear rx0", csr, 32'h0009_8240);
    check("R7 bank1 count", {21'd0, csr[26:16]}, 32'd9);

    drive(0, 32'h0, 0, 1, 0, 11'd8, 0, 0, 0); idle();
    check("R8 setup data1", csr, 32'h0009_8A44);
    check("R5 setup blocks out", {30'd0, out_rsp}, 32'd2);

    wr(32'h0000_825F);                        // arm IN
    check("R4 in ack", {30'd0, in_rsp}, 32'd1);
    drive(0, 32'h0, 0, 0, 0, 11'd0, 1, 0, 0); idle();
    check("R3 in retired", csr, 32'h0009_8245);

    wr(32'h0000_826F);                        // force stall
    check("R9 stall rsp", {28'd0, out_rsp, in_rsp}, 32'hF);
    drive(0, 32'h0, 0, 0, 0, 11'd0, 0, 1, 0); idle();
    check("R9 stall sent", csr, 32'h0009_826D);

    drive(0, 32'h0, 1, 0, 0, 11'd0, 0, 0, 0); idle();
    check("R11 ep reset", csr, 32'h0000_8220);
    check("R11 irq low", {31'd0, irq}, 32'd0);

    wr(32'h0000_8100);                        // iso OUT
    drive(0, 32'h0, 0, 0, 0, 11'd0, 0, 1, 0); idle();
    check("R9 iso no stall flag", csr, 32'h0000_8100);
    drive(0, 32'h0, 0, 0, 0, 11'd0, 0, 0, 1); idle();
    check("R9 iso error", csr, 32'h0000_8108);

    wr(32'h0000_0108);                        // disable
    check("R5 disabled none", {28'd0, out_rsp, in_rsp}, 32'h0);
    ev_out(11'd7);
    drive(0, 32'h0, 0, 1, 0, 11'd4, 0, 0, 0); idle();
    check("R12 disabled ignored", csr, 32'h0000_0108);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d;
      int sel;
      d = $urandom;
      d[15] = ($urandom % 8) != 0;
      d[5]  = ($urandom % 6) == 0;
      d[0] = ($urandom % 4) != 0; d[1] = ($urandom % 4) != 0;
      d[2] = ($urandom % 4) != 0; d[3] = ($urandom % 4) != 0;
      d[6] = ($urandom % 4) != 0;
      sel = $urandom % 8;
      drive(($urandom % 4) == 0, d, ($urandom % 64) == 0,
            sel == 1, sel == 2 || sel == 3, 11'($urandom),
            sel == 4, sel == 5, sel == 6);
    end
    idle();
    idle();
    done = 1'b1;
    finish_run();
  end
endmodule